// File: doc/BRIEF.md
# Packet-Filter VM Arithmetic/Logic Execute Unit

This unit carries out the arithmetic and logic operations of a small packet-filter virtual machine. The caller presents one operation at a time: a class bit that picks 32-bit or 64-bit semantics, a 4-bit operation code, a 16-bit modifier field, a select between the source register and a 32-bit immediate, and the current destination and source register values. The unit returns the new destination value on a result strobe. Storing that value into a register file is the caller's job.

Most operations complete in one cycle. Division and modulo with a non-zero divisor go to an iterative restoring divider, which produces one quotient bit per clock. While it runs, `busy` is high and new requests are ignored. The modifier field changes division, modulo and move into their signed or sign-extending forms. Encodings that are not defined raise an illegal flag and return the destination value as it was given.

Top module: `pfvm_alu_exec`

## Requirements
- R1: After reset, `res_valid`, `res_illegal` and `busy` are 0 and `res_data` is 0.
- R2: `op_code` values are ADD 0x0, SUB 0x1, MUL 0x2, DIV 0x3, OR 0x4, AND 0x5, LSH 0x6, RSH 0x7, NEG 0x8, MOD 0x9, XOR 0xA, MOV 0xB and ARSH 0xC. `op_wide`=1 selects the 64-bit class. `op_use_reg`=1 makes `src_val` the second operand. Otherwise the operand is `imm_val`, sign-extended to 64 bits, and the 32-bit class uses its low 32 bits as is.
- R3: ADD, SUB, MUL and NEG wrap modulo 2^64 or 2^32 and raise no flag. OR, AND and XOR are bitwise. MOV with modifier 0 copies the operand.
- R4: Every legal 32-bit class result has its upper 32 bits cleared. This includes zero-divisor modulo, which returns the low half of `dst_val`.
- R5: The shift amount is operand & 63 in the 64-bit class and operand & 31 in the 32-bit class. RSH fills with zeros. ARSH copies the sign bit of the operating width.
- R6: DIV and MOD with modifier 0 are unsigned in the operating width. A 32-bit class immediate is therefore a 32-bit unsigned divisor, and a 64-bit class immediate is sign-extended first and then taken as unsigned.
- R7: DIV and MOD with modifier 1 are signed. The quotient truncates toward zero and the remainder takes the sign of the dividend. The most negative value divided by -1 gives the most negative value, and the matching modulo gives 0.
- R8: With a zero divisor in the operating width, DIV (either form) returns 0 and MOD (either form) returns `dst_val`. Both complete in a single cycle.
- R9: MOV with modifier 8, 16 or 32 sign-extends the low 8, 16 or 32 bits of the operand. In the 32-bit class only 8 and 16 are legal, and they extend to 32 bits.
- R10: Code 0xD, 0xE or 0xF, or any code/modifier pair not listed in R2, R6, R7 or R9, gives `res_valid` with `res_illegal`=1 and `res_data` equal to `dst_val`.
- R11: A single-cycle operation presents its result in the cycle after the accepting clock edge. A divide or modulo with a non-zero divisor holds `busy` high and presents its result N+1 cycles later, where N is 32 or 64 for the class. `res_valid` stays low while `busy` is high.
- R12: `op_valid` is ignored while `busy` is high. Such a request produces no result pulse and leaves the running division unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request strobe, taken when `busy` is low |
| op_wide | input | 1 | 1 = 64-bit class, 0 = 32-bit class |
| op_code | input | 4 | Operation code (R2) |
| op_off | input | 16 | Modifier field selecting signed or extending variants |
| op_use_reg | input | 1 | 1 = use `src_val`, 0 = use `imm_val` |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| imm_val | input | 32 | Immediate operand |
| busy | output | 1 | Divider running; requests ignored |
| res_valid | output | 1 | One-cycle result strobe |
| res_illegal | output | 1 | Undefined encoding, valid with `res_valid` |
| res_data | output | 64 | New destination value |

## Verification
The bench targets the places where each class reads the same bits differently. A 32-bit subtract or logical shift that leaves `dst_val` upper bits in place gives a non-zero upper half. An immediate that is extended the wrong way turns a 32-bit unsigned divisor of 0xFFFFFFFF into -1, so the quotient comes out as 16 instead of 0. The signed divider is driven with negative dividends and divisors, with the most-negative-over-minus-one case, and with zero divisors whose upper source half is non-zero; a wrong sign fix-up or a full-width zero test returns the wrong remainder sign or starts a needless division. Requests made during a division must vanish, so a design that latches them produces a second result pulse or corrupts the quotient.

// File: rtl/pfvm_alu_pkg.sv
package pfvm_alu_pkg;
  localparam int XLEN = 64;
  localparam int HLEN = XLEN / 2;
  localparam int IMMW = 32;
  localparam int OFFW = 16;

  typedef enum logic [3:0] {
    OP_ADD = 4'h0, OP_SUB = 4'h1, OP_MUL = 4'h2, OP_DIV = 4'h3,
    OP_OR  = 4'h4, OP_AND = 4'h5, OP_LSH = 4'h6, OP_RSH = 4'h7,
    OP_NEG = 4'h8, OP_MOD = 4'h9, OP_XOR = 4'hA, OP_MOV = 4'hB,
    OP_ARSH = 4'hC, OP_SWAP = 4'hD, OP_RSVE = 4'hE, OP_RSVF = 4'hF
  } alu_op_e;

  // legality of a code/modifier pair for a class
  function automatic logic op_legal(logic wide, alu_op_e code, logic [OFFW-1:0] off);
    case (code)
      OP_DIV, OP_MOD: return (off == 16'd0) || (off == 16'd1);
      OP_MOV:         return (off == 16'd0) || (off == 16'd8) || (off == 16'd16) ||
                             (wide && off == 16'd32);
      OP_SWAP, OP_RSVE, OP_RSVF: return 1'b0;
      default:        return off == 16'd0;
    endcase
  endfunction

  function automatic logic divisor_zero(logic wide, logic [XLEN-1:0] b);
    return wide ? (b == '0) : (b[HLEN-1:0] == '0);
  endfunction

  // absolute value in the operating width, zero-extended to XLEN
  function automatic logic [XLEN-1:0] magnitude(logic wide, logic sgn, logic [XLEN-1:0] x);
    if (wide) return (sgn && x[XLEN-1]) ? -x : x;
    return {{HLEN{1'b0}}, (sgn && x[HLEN-1]) ? -x[HLEN-1:0] : x[HLEN-1:0]};
  endfunction

  // one restoring step: returns {remainder, quotient}
  function automatic logic [2*XLEN-1:0] div_step(logic [XLEN-1:0] rem, logic [XLEN-1:0] quo,
                                                 logic [XLEN-1:0] dvs);
    logic [XLEN+1:0] trial;
    trial = {1'b0, rem, quo[XLEN-1]} - {2'b00, dvs};
    if (trial[XLEN+1]) return {rem[XLEN-2:0], quo[XLEN-1], quo[XLEN-2:0], 1'b0};
    return {trial[XLEN-1:0], quo[XLEN-2:0], 1'b1};
  endfunction

  function automatic logic [XLEN-1:0] div_finish(logic wide, logic want_rem, logic neg_q,
                                                 logic neg_r, logic [XLEN-1:0] rem,
                                                 logic [XLEN-1:0] quo);
    logic [XLEN-1:0] val;
    logic            neg;
    val = want_rem ? rem : quo;
    neg = want_rem ? neg_r : neg_q;
    if (wide) return neg ? -val : val;
    return {{HLEN{1'b0}}, neg ? -val[HLEN-1:0] : val[HLEN-1:0]};
  endfunction

  // single-cycle result; DIV/MOD here only cover the zero-divisor case
  function automatic logic [XLEN-1:0] fast_op(logic wide, alu_op_e code, logic [OFFW-1:0] off,
                                              logic [XLEN-1:0] a, logic [XLEN-1:0] b);
    logic [HLEN-1:0] a32, b32, r32;
    logic [5:0]      sh64;
    logic [4:0]      sh32;
    a32 = a[HLEN-1:0];
    b32 = b[HLEN-1:0];
    sh64 = b[5:0];
    sh32 = b[4:0];
    if (wide) begin
      case (code)
        OP_ADD:  return a + b;
        OP_SUB:  return a - b;
        OP_MUL:  return a * b;
        OP_OR:   return a | b;
        OP_AND:  return a & b;
        OP_LSH:  return a << sh64;
        OP_RSH:  return a >> sh64;
        OP_NEG:  return -a;
        OP_XOR:  return a ^ b;
        OP_ARSH: return XLEN'($signed(a) >>> sh64);
        OP_MOD:  return a;
        OP_MOV: begin
          case (off)
            16'd8:   return {{56{b[7]}}, b[7:0]};
            16'd16:  return {{48{b[15]}}, b[15:0]};
            16'd32:  return {{32{b[31]}}, b[31:0]};
            default: return b;
          endcase
        end
        default: return '0;
      endcase
    end
    case (code)
      OP_ADD:  r32 = a32 + b32;
      OP_SUB:  r32 = a32 - b32;
      OP_MUL:  r32 = a32 * b32;
      OP_OR:   r32 = a32 | b32;
      OP_AND:  r32 = a32 & b32;
      OP_LSH:  r32 = a32 << sh32;
      OP_RSH:  r32 = a32 >> sh32;
      OP_NEG:  r32 = -a32;
      OP_XOR:  r32 = a32 ^ b32;
      OP_ARSH: r32 = HLEN'($signed(a32) >>> sh32);
      OP_MOD:  r32 = a32;
      OP_MOV: begin
        case (off)
          16'd8:   r32 = {{24{b32[7]}}, b32[7:0]};
          16'd16:  r32 = {{16{b32[15]}}, b32[15:0]};
          default: r32 = b32;
        endcase
      end
      default: r32 = '0;
    endcase
    return {{HLEN{1'b0}}, r32};
  endfunction
endpackage

// File: rtl/pfvm_operand_sel.sv
module pfvm_operand_sel
  import pfvm_alu_pkg::*;
(
  input  logic            use_reg,
  input  logic [XLEN-1:0] src_val,
  input  logic [IMMW-1:0] imm_val,
  output logic [XLEN-1:0] opnd_b
);
  localparam int EXT = XLEN - IMMW;

  always_comb begin
    if (use_reg) opnd_b = src_val;
    else         opnd_b = {{EXT{imm_val[IMMW-1]}}, imm_val};
  end
endmodule

// File: rtl/pfvm_alu_fast.sv
module pfvm_alu_fast
  import pfvm_alu_pkg::*;
(
  input  logic            op_wide,
  input  logic [3:0]      op_code,
  input  logic [OFFW-1:0] op_off,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  output logic            legal,
  output logic            needs_div,
  output logic            div_signed,
  output logic            div_rem,
  output logic [XLEN-1:0] fast_res
);
  alu_op_e code;
  logic    is_divmod;

  always_comb begin
    code       = alu_op_e'(op_code);
    legal      = op_legal(op_wide, code, op_off);
    is_divmod  = (code == OP_DIV) || (code == OP_MOD);
    needs_div  = legal && is_divmod && !divisor_zero(op_wide, opnd_b);
    div_signed = op_off[0];
    div_rem    = (code == OP_MOD);
    fast_res   = fast_op(op_wide, code, op_off, opnd_a, opnd_b);
  end
endmodule

// File: rtl/pfvm_divider.sv
module pfvm_divider
  import pfvm_alu_pkg::*;
#(
  parameter int DW    = XLEN,
  localparam int CNTW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wide,
  input  logic          sgn,
  input  logic          want_rem,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result
);
  typedef enum logic [1:0] {DV_IDLE, DV_RUN, DV_FIN} dv_state_e;

  dv_state_e      state;
  logic [DW-1:0]  rem_q, quo_q, dvs_q;
  logic [CNTW-1:0] cnt_q;
  logic           wide_q, rem_sel_q, neg_q_q, neg_r_q;
  logic           neg_a, neg_b;
  logic [DW-1:0]  mag_a, mag_b;
  logic [2*DW-1:0] step;

  always_comb begin
    neg_a = sgn && (wide ? dividend[DW-1] : dividend[HLEN-1]);
    neg_b = sgn && (wide ? divisor[DW-1]  : divisor[HLEN-1]);
    mag_a = magnitude(wide, sgn, dividend);
    mag_b = magnitude(wide, sgn, divisor);
    step  = div_step(rem_q, quo_q, dvs_q);
  end

  assign busy = (state != DV_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= DV_IDLE;
      rem_q     <= '0;
      quo_q     <= '0;
      dvs_q     <= '0;
      cnt_q     <= '0;
      wide_q    <= 1'b0;
      rem_sel_q <= 1'b0;
      neg_q_q   <= 1'b0;
      neg_r_q   <= 1'b0;
      done      <= 1'b0;
      result    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        DV_IDLE: if (start) begin
          state     <= DV_RUN;
          rem_q     <= '0;
          quo_q     <= wide ? mag_a : {mag_a[HLEN-1:0], {HLEN{1'b0}}};
          dvs_q     <= mag_b;
          cnt_q     <= wide ? CNTW'(DW - 1) : CNTW'(HLEN - 1);
          wide_q    <= wide;
          rem_sel_q <= want_rem;
          neg_q_q   <= neg_a ^ neg_b;
          neg_r_q   <= neg_a;
        end
        DV_RUN: begin
          {rem_q, quo_q} <= step;
          cnt_q          <= cnt_q - 1'b1;
          if (cnt_q == '0) state <= DV_FIN;
        end
        default: begin
          result <= div_finish(wide_q, rem_sel_q, neg_q_q, neg_r_q, rem_q, quo_q);
          done   <= 1'b1;
          state  <= DV_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/pfvm_alu_exec.sv
module pfvm_alu_exec
  import pfvm_alu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic            op_wide,
  input  logic [3:0]      op_code,
  input  logic [OFFW-1:0] op_off,
  input  logic            op_use_reg,
  input  logic [XLEN-1:0] dst_val,
  input  logic [XLEN-1:0] src_val,
  input  logic [IMMW-1:0] imm_val,
  output logic            busy,
  output logic            res_valid,
  output logic            res_illegal,
  output logic [XLEN-1:0] res_data
);
  logic [XLEN-1:0] opnd_b, fast_res, div_res, fast_data;
  logic legal, needs_div, div_signed, div_rem;
  logic accept, start_div, fast_go, div_busy, div_done;
  logic fast_v, fast_ill;

  pfvm_operand_sel u_opnd (
    .use_reg(op_use_reg), .src_val(src_val), .imm_val(imm_val), .opnd_b(opnd_b)
  );

  pfvm_alu_fast u_fast (
    .op_wide(op_wide), .op_code(op_code), .op_off(op_off), .opnd_a(dst_val),
    .opnd_b(opnd_b), .legal(legal), .needs_div(needs_div), .div_signed(div_signed),
    .div_rem(div_rem), .fast_res(fast_res)
  );

  assign accept    = op_valid && !div_busy;
  assign start_div = accept && needs_div;
  assign fast_go   = accept && !needs_div;

  pfvm_divider #(.DW(XLEN)) u_div (
    .clk(clk), .rst_n(rst_n), .start(start_div), .wide(op_wide), .sgn(div_signed),
    .want_rem(div_rem), .dividend(dst_val), .divisor(opnd_b), .busy(div_busy),
    .done(div_done), .result(div_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast_v    <= 1'b0;
      fast_ill  <= 1'b0;
      fast_data <= '0;
    end else begin
      fast_v   <= fast_go;
      fast_ill <= fast_go && !legal;
      if (fast_go) fast_data <= legal ? fast_res : dst_val;
    end
  end

  assign busy        = div_busy;
  assign res_valid   = fast_v || div_done;
  assign res_illegal = fast_ill;
  assign res_data    = div_done ? div_res : fast_data;
endmodule

// File: rtl/pfvm_alu_exec_chk.sv
module pfvm_alu_exec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_wide,
  input logic [63:0] dst_val,
  input logic        busy,
  input logic        res_valid,
  input logic        res_illegal,
  input logic [63:0] res_data,
  input logic        accept,
  input logic        start_div,
  input logic        div_done
);
  logic wide_cap;

  always_ff @(posedge clk) begin
    if (!rst_n)      wide_cap <= 1'b1;
    else if (accept) wide_cap <= op_wide;
  end

  AST_ILLEGAL_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n) res_illegal |-> res_valid); // R10
  AST_ILLEGAL_KEEPS_DST: assert property (@(posedge clk) disable iff (!rst_n) res_illegal |-> res_data == $past(dst_val)); // R10
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && !res_illegal && !wide_cap) |-> res_data[63:32] == 32'd0); // R4
  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !res_valid); // R11
  AST_DIV_ENDS_IN_RESULT: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (div_done && res_valid)); // R11
  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n) start_div |=> busy); // R11
  AST_NO_ACCEPT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !accept); // R12
endmodule

bind pfvm_alu_exec pfvm_alu_exec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_wide(op_wide), .dst_val(dst_val), .busy(busy),
  .res_valid(res_valid), .res_illegal(res_illegal), .res_data(res_data),
  .accept(accept), .start_div(start_div), .div_done(div_done)
);

// File: tb/tb_pfvm_alu_exec.sv
module tb_pfvm_alu_exec;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_wide = 1'b0;
  logic [3:0]  op_code = 4'h0;
  logic [15:0] op_off = 16'd0;
  logic        op_use_reg = 1'b0;
  logic [63:0] dst_val = '0;
  logic [63:0] src_val = '0;
  logic [31:0] imm_val = '0;
  logic        busy, res_valid, res_illegal;
  logic [63:0] res_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfvm_alu_exec dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_wide(op_wide), .op_code(op_code),
    .op_off(op_off), .op_use_reg(op_use_reg), .dst_val(dst_val), .src_val(src_val),
    .imm_val(imm_val), .busy(busy), .res_valid(res_valid), .res_illegal(res_illegal),
    .res_data(res_data)
  );

  task automatic check(input string req, input string what, input logic [63:0] got,
                       input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // issue one request; lat = cycles after the accepting edge until res_valid
  task automatic issue(input logic wide, input logic [3:0] code, input logic [15:0] off,
                       input logic use_reg, input logic [63:0] dst, input logic [63:0] src,
                       input logic [31:0] imm, output logic [63:0] res, output logic ill,
                       output int lat);
    @(negedge clk);
    op_wide = wide; op_code = code; op_off = off; op_use_reg = use_reg;
    dst_val = dst; src_val = src; imm_val = imm; op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    lat = 0;
    while (!res_valid && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    res = res_data;
    ill = res_illegal;
  endtask

  task automatic run_op(input string req, input string what, input logic wide,
                        input logic [3:0] code, input logic [15:0] off, input logic use_reg,
                        input logic [63:0] dst, input logic [63:0] src, input logic [31:0] imm,
                        input logic [63:0] exp, input int exp_lat);
    logic [63:0] r;
    logic        il;
    int          lt;
    issue(wide, code, off, use_reg, dst, src, imm, r, il, lt);
    check(req, {what, " data"}, r, exp);
    check(req, {what, " latency"}, 64'(lt), 64'(exp_lat));
    check("R10", {what, " legal"}, {63'd0, il}, 64'd0);
  endtask

  task automatic t_reset;
    check("R1", "reset res_valid", {63'd0, res_valid}, 64'd0);
    check("R1", "reset res_illegal", {63'd0, res_illegal}, 64'd0);
    check("R1", "reset busy", {63'd0, busy}, 64'd0);
    check("R1", "reset res_data", res_data, 64'd0);
  endtask

  task automatic t_arith;
    run_op("R3", "add64 wrap", 1, 4'h0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 0, 64'd1, 0);
    run_op("R4", "sub32 wrap", 0, 4'h1, 0, 1, 64'hDEAD_0000_0000_0000, 64'd1, 0,
           64'h0000_0000_FFFF_FFFF, 0);
    run_op("R3", "mul64", 1, 4'h2, 0, 1, 64'h1_0000_0001, 64'h1_0000_0001, 0,
           64'h0000_0002_0000_0001, 0);
    run_op("R3", "neg64", 1, 4'h8, 0, 1, 64'd5, 0, 0, 64'hFFFF_FFFF_FFFF_FFFB, 0);
    run_op("R2", "xor64 imm sext", 1, 4'hA, 0, 0, 64'h0123_4567_89AB_CDEF, 0, 32'hFFFF_FFFF,
           64'hFEDC_BA98_7654_3210, 0);
    run_op("R2", "and32 imm", 0, 4'h5, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 32'h00FF_00FF,
           64'h0000_0000_00FF_00FF, 0);
    run_op("R2", "mov64 imm sext", 1, 4'hB, 0, 0, 0, 0, 32'h8000_0000,
           64'hFFFF_FFFF_8000_0000, 0);
    run_op("R3", "or64", 1, 4'h4, 0, 1, 64'hF000_0000_0000_0000, 64'h0F, 0,
           64'hF000_0000_0000_000F, 0);
  endtask

  task automatic t_shift;
    run_op("R5", "lsh64 mask", 1, 4'h6, 0, 1, 64'd3, 64'd65, 0, 64'd6, 0);
    run_op("R5", "lsh32 mask", 0, 4'h6, 0, 1, 64'h8000_0000_4000_0001, 64'd33, 0,
           64'h0000_0000_8000_0002, 0);
    run_op("R5", "rsh32 logical", 0, 4'h7, 0, 1, 64'hFFFF_FFFF_8000_0000, 64'd1, 0,
           64'h0000_0000_4000_0000, 0);
    run_op("R5", "arsh64", 1, 4'hC, 0, 1, 64'h8000_0000_0000_0000, 64'd4, 0,
           64'hF800_0000_0000_0000, 0);
    run_op("R5", "arsh32", 0, 4'hC, 0, 1, 64'h0000_0000_8000_0000, 64'd31, 0,
           64'h0000_0000_FFFF_FFFF, 0);
  endtask

  task automatic t_udiv;
    run_op("R6", "udiv64", 1, 4'h3, 0, 1, 64'd100, 64'd7, 0, 64'd14, 65);
    run_op("R6", "umod32", 0, 4'h9, 0, 1, 64'd100, 64'd7, 0, 64'd2, 33);
    run_op("R6", "udiv64 imm sext", 1, 4'h3, 0, 0, 64'hFFFF_FFFF_FFFF_FFFE, 0, 32'hFFFF_FFFF,
           64'd0, 65);
    run_op("R6", "udiv32 imm unsigned", 0, 4'h3, 0, 0, 64'hFFFF_FFF0, 0, 32'hFFFF_FFFF,
           64'd0, 33);
    run_op("R6", "umod64 big", 1, 4'h9, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1_0000_0000, 0,
           64'hFFFF_FFFF, 65);
  endtask

  task automatic t_sdiv;
    run_op("R7", "sdiv64 neg", 1, 4'h3, 1, 1, -64'sd7, 64'd2, 0, 64'hFFFF_FFFF_FFFF_FFFD, 65);
    run_op("R7", "smod64 neg dividend", 1, 4'h9, 1, 1, -64'sd7, 64'd2, 0,
           64'hFFFF_FFFF_FFFF_FFFF, 65);
    run_op("R7", "smod64 neg divisor", 1, 4'h9, 1, 1, 64'd7, -64'sd2, 0, 64'd1, 65);
    run_op("R7", "sdiv32 neg", 0, 4'h3, 1, 1, 64'h0000_0000_FFFF_FF9C, 64'd7, 0,
           64'h0000_0000_FFFF_FFF2, 33);
    run_op("R7", "sdiv64 min/-1", 1, 4'h3, 1, 1, 64'h8000_0000_0000_0000, -64'sd1, 0,
           64'h8000_0000_0000_0000, 65);
    run_op("R7", "smod64 min/-1", 1, 4'h9, 1, 1, 64'h8000_0000_0000_0000, -64'sd1, 0,
           64'd0, 65);
    run_op("R7", "sdiv32 min/-1", 0, 4'h3, 1, 0, 64'h8000_0000, 0, 32'hFFFF_FFFF,
           64'h0000_0000_8000_0000, 33);
    run_op("R7", "sdiv64 imm", 1, 4'h3, 1, 0, 64'd9, 0, 32'hFFFF_FFFD,
           64'hFFFF_FFFF_FFFF_FFFD, 65);
  endtask

  task automatic t_divzero;
    run_op("R8", "udiv64 by 0", 1, 4'h3, 0, 1, 64'd55, 64'd0, 0, 64'd0, 0);
    run_op("R8", "umod64 by 0", 1, 4'h9, 0, 1, 64'hAAAA_BBBB_CCCC_DDDD, 64'd0, 0,
           64'hAAAA_BBBB_CCCC_DDDD, 0);
    run_op("R8", "smod32 by 0 upper src", 0, 4'h9, 1, 1, 64'hAAAA_BBBB_1234_5678,
           64'h1_0000_0000, 0, 64'h0000_0000_1234_5678, 0);
    run_op("R8", "sdiv32 by 0 imm", 0, 4'h3, 1, 0, 64'd77, 0, 32'd0, 64'd0, 0);
  endtask

  task automatic t_movsx;
    run_op("R9", "movsx64 b8", 1, 4'hB, 16'd8, 1, 0, 64'h80, 0, 64'hFFFF_FFFF_FFFF_FF80, 0);
    run_op("R9", "movsx64 b16 pos", 1, 4'hB, 16'd16, 1, 0, 64'hFFFF_7FFF, 0, 64'h7FFF, 0);
    run_op("R9", "movsx64 b32", 1, 4'hB, 16'd32, 1, 0, 64'h1234_5678_8000_0000, 0,
           64'hFFFF_FFFF_8000_0000, 0);
    run_op("R9", "movsx32 b8", 0, 4'hB, 16'd8, 1, 64'hFFFF_0000_0000_0000, 64'h1FF, 0,
           64'h0000_0000_FFFF_FFFF, 0);
    run_op("R9", "movsx32 b16", 0, 4'hB, 16'd16, 1, 0, 64'h8000, 0, 64'h0000_0000_FFFF_8000, 0);
  endtask

  task automatic bad_op(input string what, input logic wide, input logic [3:0] code,
                        input logic [15:0] off, input logic [63:0] dst);
    logic [63:0] r;
    logic        il;
    int          lt;
    issue(wide, code, off, 1, dst, 64'h5, 0, r, il, lt);
    check("R10", {what, " flag"}, {63'd0, il}, 64'd1);
    check("R10", {what, " dst kept"}, r, dst);
    check("R10", {what, " latency"}, 64'(lt), 64'd0);
  endtask

  task automatic t_illegal;
    bad_op("movsx32 b32", 0, 4'hB, 16'd32, 64'h1111_2222_3333_4444);
    bad_op("code D", 1, 4'hD, 16'd0, 64'h5555_6666_7777_8888);
    bad_op("code E", 0, 4'hE, 16'd0, 64'h9999_AAAA_BBBB_CCCC);
    bad_op("add off1", 1, 4'h0, 16'd1, 64'hCAFE_F00D_0000_0001);
    bad_op("div off2", 1, 4'h3, 16'd2, 64'hFFFF_FFFF_0000_0007);
  endtask

  task automatic t_busy_ignore;
    int pulses = 0;
    logic [63:0] last = '0;
    @(negedge clk);
    op_wide = 1; op_code = 4'h3; op_off = 0; op_use_reg = 1;
    dst_val = 64'd1000; src_val = 64'd10; op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R11", "busy after divide start", {63'd0, busy}, 64'd1);
    op_code = 4'h0; dst_val = 64'd1; src_val = 64'd1;
    for (int i = 0; i < 100; i++) begin
      if (i == 6) op_valid = 1'b0;
      if (res_valid) begin
        pulses++;
        last = res_data;
      end
      @(negedge clk);
    end
    check("R12", "result pulses", 64'(pulses), 64'd1);
    check("R12", "divide result", last, 64'd100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_arith;
    t_shift;
    t_udiv;
    t_sdiv;
    t_divzero;
    t_movsx;
    t_illegal;
    t_busy_ignore;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule